// File: doc/BRIEF.md
# Serial Video Lane Test Symbol Source

This block supplies one 10-bit symbol per clock to a single lane of a serial video link and lets the link be driven from a test source as well as from live video. A 3-bit source code picks what goes out. The choices are a constant zero, the incoming live symbol, a pseudo-random bit stream, or a user-programmed sequence of eight 10-bit words. The chosen symbol is registered, so the lane sees it one clock after it is selected.

The pseudo-random engine can run one of four LFSR polynomials. On each cycle it can emit 1, 8 or 10 fresh bits. The word-sequence engine steps through its eight words in a fixed order, and it can hold each word for one to eight clocks. A separate 40-bit clock-lane pattern register can be loaded on command. It can also be rotated by one symbol per clock, which suits a clock lane that runs at a quarter of the character rate.

Each engine keeps running whenever it is enabled, whichever source is shown at the output. Serialisation and the register bus that sets the controls lie outside this block.

Top module: `tmds_pattern_gen`

## Requirements
- R1: Asynchronous active-low reset clears `sym_out` and `clk_sym_out` to zero. It sets the LFSR state to all ones, the stored polynomial code to 0, the word index and repeat counter to 0, and the clock-lane pattern to zero.
- R2: `sym_out` is registered. One cycle after the inputs are sampled it shows one of the following, chosen by `out_sel`:
  - 3'b000 gives zero.
  - 3'b001 gives `data_in`.
  - 3'b010 gives the pseudo-random engine output.
  - 3'b100 gives the word-sequence engine output.
  - Every other code gives zero.
- R3: `prbs_mode` selects the polynomial:
  - 0 is x^11+x^9+1, with new bit s[10]^s[8].
  - 1 is x^15+x^14+1, with new bit s[14]^s[13].
  - 2 is x^7+x^6+1, with new bit s[6]^s[5].
  - 3 is x^31+x^28+1, with new bit s[30]^s[27].

  Each new bit is shifted in at s[0], and output bit k is the k-th bit generated in that cycle. In any cycle where `prbs_mode` differs from the stored code, the state is first re-seeded to all ones and the code is stored.
- R4: `prbs_width` sets how many bits each cycle produces, and the LFSR advances by the same count:
  - 3 produces 10 bits, all placed on the symbol.
  - 1 produces 8 bits, placed in bits [7:0], with bits [9:8] set to 0.
  - 2 produces 1 bit, copied to all 10 symbol bits.
- R5: With `prbs_en` low or `prbs_width` = 0, the pseudo-random output is zero and the LFSR holds its state. Re-seeding on a mode change still applies.
- R6: Word i of the sequence is `shift_pattern[10*i+9:10*i]`. After reset the engine starts at word 0, and the index wraps from 7 back to 0.
- R7: With `shift_en` high, each word is presented for `shift_repeat`+1 consecutive enabled cycles before the next word follows.
- R8: With `shift_en` low, the word-sequence output is zero, and the word index and repeat counter hold.
- R9: A cycle with `clk_load` high copies `clk_pattern` into the clock-lane register, even if `clk_rotate` is also high. Right after that edge, `clk_sym_out` equals `clk_pattern[9:0]`.
- R10: A cycle with `clk_rotate` high and `clk_load` low rotates the register right by 10 bits. As a result, `clk_sym_out` steps through pattern words 0, 1, 2, 3 and then 0 again.
- R11: With both `clk_load` and `clk_rotate` low, the clock-lane register and `clk_sym_out` hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_sel | input | 3 | Output source code |
| data_in | input | 10 | Live symbol for pass-through |
| prbs_en | input | 1 | Pseudo-random engine run enable |
| prbs_mode | input | 2 | Polynomial code |
| prbs_width | input | 2 | Bits per cycle code |
| shift_en | input | 1 | Word-sequence engine run enable |
| shift_repeat | input | 3 | Word hold count minus one |
| shift_pattern | input | 80 | Eight 10-bit words, word 0 in the low bits |
| clk_pattern | input | 40 | Clock-lane pattern to load |
| clk_load | input | 1 | Load clock-lane pattern |
| clk_rotate | input | 1 | Rotate clock-lane pattern by one symbol |
| sym_out | output | 10 | Registered lane symbol |
| clk_sym_out | output | 10 | Current clock-lane symbol |

## Verification
`sym_out` is due exactly one clock after the edge at which the controls and engine state were sampled. This is because the engine outputs are computed from the state before that edge and then pass through the single output register. `clk_sym_out` comes straight from the clock-lane register, so a load or rotate shows right after the edge that captures it. The bench drives inputs on the falling edge and updates its reference model from the inputs present at each rising edge. It compares both outputs 1 ns after that same rising edge, so each expected value lines up with the edge that produced it.

// File: rtl/tmds_pg_pkg.sv
package tmds_pg_pkg;

    localparam int LFSR_W = 31;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OSEL_ZERO  = 3'b000,
        OSEL_DATA  = 3'b001,
        OSEL_PRBS  = 3'b010,
        OSEL_SHIFT = 3'b100
    } osel_e;

    typedef enum logic [1:0] {
        PM_P11 = 2'd0,
        PM_P15 = 2'd1,
        PM_P7  = 2'd2,
        PM_P31 = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_BYTE = 2'd1,
        PW_BIT  = 2'd2,
        PW_SYM  = 2'd3
    } pwidth_e;

    // Feedback bit of the selected polynomial; new bits enter at bit 0.
    function automatic logic prbs_feedback(logic [LFSR_W-1:0] s, logic [1:0] m);
        logic fb;
        case (pmode_e'(m))
            PM_P11:  fb = s[10] ^ s[8];
            PM_P15:  fb = s[14] ^ s[13];
            PM_P7:   fb = s[6]  ^ s[5];
            default: fb = s[30] ^ s[27];
        endcase
        return fb;
    endfunction

endpackage

// File: rtl/tmds_prbs_engine.sv
module tmds_prbs_engine
    import tmds_pg_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic [1:0]       width,
    output logic [SYM_W-1:0] sym
);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [1:0]        mode;
    } prbs_st_t;

    prbs_st_t          st_d, st_q;
    logic [LFSR_W-1:0] seed_start;
    logic [LFSR_W-1:0] walk;
    logic [SYM_W-1:0]  gen_bits;
    int                nbits;
    logic              run;

    always_comb begin
        // Re-seed when the polynomial choice changes so no zero lock-up.
        seed_start = (mode != st_q.mode) ? '1 : st_q.lfsr;

        case (pwidth_e'(width))
            PW_BYTE: nbits = BYTE_W;
            PW_BIT:  nbits = 1;
            PW_SYM:  nbits = SYM_W;
            default: nbits = 0;
        endcase
        run = en && (nbits != 0);

        walk     = seed_start;
        gen_bits = '0;
        for (int k = 0; k < SYM_W; k++) begin
            if (k < nbits) begin
                gen_bits[k] = prbs_feedback(walk, mode);
                walk        = {walk[LFSR_W-2:0], gen_bits[k]};
            end
        end

        st_d.mode = mode;
        st_d.lfsr = run ? walk : seed_start;

        sym = '0;
        if (run) begin
            case (pwidth_e'(width))
                PW_BYTE: sym[BYTE_W-1:0] = gen_bits[BYTE_W-1:0];
                PW_BIT:  sym = {SYM_W{gen_bits[0]}};
                default: sym = gen_bits;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr <= '1;
            st_q.mode <= 2'd0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmds_shift_engine.sv
module tmds_shift_engine #(
    parameter int SYM_W = 10,
    parameter int WORDS = 8,
    parameter int REP_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [REP_W-1:0]       repeat_cnt,
    input  logic [SYM_W*WORDS-1:0] pattern,
    output logic [SYM_W-1:0]       sym
);

    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [REP_W-1:0] cnt;
    } shift_st_t;

    shift_st_t        st_d, st_q;
    logic [SYM_W-1:0] word_arr [WORDS];

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_words
        assign word_arr[gi] = pattern[gi*SYM_W +: SYM_W];
    end

    always_comb begin
        st_d = st_q;
        sym  = '0;
        if (en) begin
            sym = word_arr[st_q.idx];
            if (st_q.cnt == repeat_cnt) begin
                st_d.cnt = '0;
                st_d.idx = (st_q.idx == LAST_IDX) ? '0 : st_q.idx + 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmds_clk_lane.sv
module tmds_clk_lane #(
    parameter int SYM_W     = 10,
    parameter int CLK_WORDS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       rotate,
    input  logic [SYM_W*CLK_WORDS-1:0] pattern,
    output logic [SYM_W-1:0]           sym
);

    localparam int PAT_W = SYM_W * CLK_WORDS;

    typedef struct packed {
        logic [PAT_W-1:0] pat;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.pat = pattern;
        end else if (rotate) begin
            st_d.pat = {st_q.pat[SYM_W-1:0], st_q.pat[PAT_W-1:SYM_W]};
        end
        sym = st_q.pat[SYM_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmds_pattern_gen.sv
module tmds_pattern_gen
    import tmds_pg_pkg::*;
#(
    parameter int SYM_W     = 10,
    parameter int WORDS     = 8,
    parameter int REP_W     = 3,
    parameter int CLK_WORDS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 out_sel,
    input  logic [SYM_W-1:0]           data_in,
    input  logic                       prbs_en,
    input  logic [1:0]                 prbs_mode,
    input  logic [1:0]                 prbs_width,
    input  logic                       shift_en,
    input  logic [REP_W-1:0]           shift_repeat,
    input  logic [SYM_W*WORDS-1:0]     shift_pattern,
    input  logic [SYM_W*CLK_WORDS-1:0] clk_pattern,
    input  logic                       clk_load,
    input  logic                       clk_rotate,
    output logic [SYM_W-1:0]           sym_out,
    output logic [SYM_W-1:0]           clk_sym_out
);

    typedef struct packed {
        logic [SYM_W-1:0] sym;
    } out_st_t;

    out_st_t          out_d, out_q;
    logic [SYM_W-1:0] prbs_sym;
    logic [SYM_W-1:0] shift_sym;

    tmds_prbs_engine #(.SYM_W(SYM_W)) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (prbs_en),
        .mode  (prbs_mode),
        .width (prbs_width),
        .sym   (prbs_sym)
    );

    tmds_shift_engine #(.SYM_W(SYM_W), .WORDS(WORDS), .REP_W(REP_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (shift_en),
        .repeat_cnt (shift_repeat),
        .pattern    (shift_pattern),
        .sym        (shift_sym)
    );

    tmds_clk_lane #(.SYM_W(SYM_W), .CLK_WORDS(CLK_WORDS)) u_clk_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (clk_load),
        .rotate  (clk_rotate),
        .pattern (clk_pattern),
        .sym     (clk_sym_out)
    );

    always_comb begin
        case (out_sel)
            OSEL_DATA:  out_d.sym = data_in;
            OSEL_PRBS:  out_d.sym = prbs_sym;
            OSEL_SHIFT: out_d.sym = shift_sym;
            default:    out_d.sym = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sym_out = out_q.sym;

endmodule

// File: rtl/tmds_pattern_gen_chk.sv
module tmds_pattern_gen_chk #(
    parameter int SYM_W     = 10,
    parameter int CLK_WORDS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [2:0]                 out_sel,
    input logic [SYM_W-1:0]           data_in,
    input logic                       prbs_en,
    input logic [1:0]                 prbs_width,
    input logic                       shift_en,
    input logic [SYM_W*CLK_WORDS-1:0] clk_pattern,
    input logic                       clk_load,
    input logic                       clk_rotate,
    input logic [SYM_W-1:0]           sym_out,
    input logic [SYM_W-1:0]           clk_sym_out
);

    // R2
    zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b000) |=> (sym_out == '0));

    // R2
    pass_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b001) |=> (sym_out == $past(data_in)));

    // R4
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && prbs_width == 2'd1) |=> (sym_out[SYM_W-1:8] == '0));

    // R4
    bit_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && prbs_width == 2'd2)
        |=> (sym_out == '0 || sym_out == '1));

    // R5
    prbs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && (!prbs_en || prbs_width == 2'd0)) |=> (sym_out == '0));

    // R8
    shift_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b100 && !shift_en) |=> (sym_out == '0));

    // R9
    clk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_load |=> (clk_sym_out == $past(clk_pattern[SYM_W-1:0])));

    // R11
    clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_load && !clk_rotate) |=> $stable(clk_sym_out));

endmodule

bind tmds_pattern_gen tmds_pattern_gen_chk #(.SYM_W(SYM_W), .CLK_WORDS(CLK_WORDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_sel     (out_sel),
    .data_in     (data_in),
    .prbs_en     (prbs_en),
    .prbs_width  (prbs_width),
    .shift_en    (shift_en),
    .clk_pattern (clk_pattern),
    .clk_load    (clk_load),
    .clk_rotate  (clk_rotate),
    .sym_out     (sym_out),
    .clk_sym_out (clk_sym_out)
);

// File: tb/tmds_pattern_gen_tb.sv
`timescale 1ns/1ps
module tmds_pattern_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  out_sel;
    logic [9:0]  data_in;
    logic        prbs_en;
    logic [1:0]  prbs_mode;
    logic [1:0]  prbs_width;
    logic        shift_en;
    logic [2:0]  shift_repeat;
    logic [79:0] shift_pattern;
    logic [39:0] clk_pattern;
    logic        clk_load;
    logic        clk_rotate;
    logic [9:0]  sym_out;
    logic [9:0]  clk_sym_out;

    always #2 clk = ~clk;

    tmds_pattern_gen u_dut (
        .clk(clk), .rst_n(rst_n), .out_sel(out_sel), .data_in(data_in),
        .prbs_en(prbs_en), .prbs_mode(prbs_mode), .prbs_width(prbs_width),
        .shift_en(shift_en), .shift_repeat(shift_repeat), .shift_pattern(shift_pattern),
        .clk_pattern(clk_pattern), .clk_load(clk_load), .clk_rotate(clk_rotate),
        .sym_out(sym_out), .clk_sym_out(clk_sym_out)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done   = 0;
    string sym_req = "R1";
    string clk_req = "R1";

    // Behavioural reference state
    logic [30:0] m_lfsr;
    logic [1:0]  m_mode;
    int          m_idx, m_cnt;
    logic [39:0] m_clk;
    logic [9:0]  exp_sym, exp_clk;

    function automatic logic poly_bit(logic [30:0] s, logic [1:0] m);
        case (m)
            2'd0:    return s[10] ^ s[8];
            2'd1:    return s[14] ^ s[13];
            2'd2:    return s[6] ^ s[5];
            default: return s[30] ^ s[27];
        endcase
    endfunction

    always @(posedge clk) begin
        logic [9:0] pr, sh, g;
        int n;
        if (!rst_n) begin
            m_lfsr = '1; m_mode = 2'd0; m_idx = 0; m_cnt = 0; m_clk = '0;
            exp_sym = '0; exp_clk = '0;
        end else begin
            if (prbs_mode != m_mode) begin
                m_lfsr = '1;
                m_mode = prbs_mode;
            end
            case (prbs_width)
                2'd3:    n = 10;
                2'd1:    n = 8;
                2'd2:    n = 1;
                default: n = 0;
            endcase
            pr = '0; g = '0;
            if (prbs_en && n > 0) begin
                for (int k = 0; k < n; k++) begin
                    g[k]   = poly_bit(m_lfsr, m_mode);
                    m_lfsr = {m_lfsr[29:0], g[k]};
                end
                pr = (n == 10) ? g : (n == 8) ? {2'b00, g[7:0]} : {10{g[0]}};
            end
            sh = '0;
            if (shift_en) begin
                sh = shift_pattern[m_idx*10 +: 10];
                if (m_cnt == int'(shift_repeat)) begin
                    m_cnt = 0;
                    m_idx = (m_idx + 1) % 8;
                end else begin
                    m_cnt++;
                end
            end
            case (out_sel)
                3'b001:  exp_sym = data_in;
                3'b010:  exp_sym = pr;
                3'b100:  exp_sym = sh;
                default: exp_sym = '0;
            endcase
            if (clk_load) m_clk = clk_pattern;
            else if (clk_rotate) m_clk = {m_clk[9:0], m_clk[39:10]};
            exp_clk = m_clk[9:0];
        end
        #1;
        if (!done) begin
            checks++;
            if (sym_out !== exp_sym) begin
                errors++;
                $display("FAIL %s sym_out actual=%h expected=%h at %0t", sym_req, sym_out, exp_sym, $time);
            end
            checks++;
            if (clk_sym_out !== exp_clk) begin
                errors++;
                $display("FAIL %s clk_sym_out actual=%h expected=%h at %0t", clk_req, clk_sym_out, exp_clk, $time);
            end
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; out_sel = 0; data_in = 0; prbs_en = 0; prbs_mode = 0; prbs_width = 0;
        shift_en = 0; shift_repeat = 0; clk_pattern = 0; clk_load = 0; clk_rotate = 0;
        for (int i = 0; i < 8; i++) shift_pattern[i*10 +: 10] = 10'(i * 123 + 17);
        cycles(3);                       // R1 reset state compared every cycle
        rst_n = 1;
        cycles(2);

        sym_req = "R2";                  // pass-through and invalid codes
        out_sel = 3'b001;
        for (int i = 0; i < 8; i++) begin data_in = 10'(i * 97 + 5); cycles(1); end
        out_sel = 3'b011; cycles(3);
        out_sel = 3'b111; cycles(3);
        out_sel = 3'b000; cycles(2);

        out_sel = 3'b010; prbs_en = 1;
        for (int m = 0; m < 4; m++) begin
            prbs_mode = 2'(m);
            sym_req = "R3"; prbs_width = 2'd3; cycles(24);
            sym_req = "R4"; prbs_width = 2'd1; cycles(24);
            prbs_width = 2'd2; cycles(24);
        end
        sym_req = "R5";
        prbs_mode = 2'd2; prbs_width = 2'd0; cycles(4);
        prbs_width = 2'd3; prbs_en = 0; cycles(4);
        prbs_en = 1; cycles(10);
        prbs_en = 0; prbs_mode = 2'd1; cycles(3);
        prbs_en = 1; cycles(6);

        out_sel = 3'b100; shift_en = 1;
        sym_req = "R6"; shift_repeat = 3'd0; cycles(20);
        sym_req = "R7"; shift_repeat = 3'd2; cycles(30);
        shift_repeat = 3'd7; cycles(40);
        sym_req = "R8"; shift_en = 0; cycles(6);
        shift_en = 1; cycles(12);

        clk_pattern = 40'hA5_3C_0F_F0_96;
        clk_req = "R9"; clk_load = 1; cycles(1);
        clk_req = "R10"; clk_load = 0; clk_rotate = 1; cycles(9);
        clk_req = "R11"; clk_rotate = 0; cycles(5);
        clk_req = "R9"; clk_pattern = 40'h12_34_56_78_9A; clk_load = 1; clk_rotate = 1; cycles(1);
        clk_load = 0; clk_rotate = 0; cycles(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule